// File: doc/BRIEF.md
# Page-Buffered Flash Program Sequencer

This block takes the command writes for buffered flash programming and turns them into array writes. After an unlock indication it expects a load command written inside the target sector. The next write states how many words follow, given as the count minus one. The words that follow are collected into a small page buffer. A confirm command then commits all the buffered words to the memory array in one pass.

All data words of one load must sit in one page. The page is the address with its low index bits removed, and the first data write picks it. Within that page, words may arrive in any order, and a repeated location keeps only its newest data. Any breach of the sequence sets a sticky abort indication and writes nothing. That indication clears only after a fresh unlock indication followed by a reset command.

The array is reached through a shared address bus, a combinational read-data input and a write strobe. During commit the block reads each location it is about to write and writes the bitwise AND of the old word and the buffered word, so programming can only clear bits. The block then holds busy for a fixed settling interval.

Top module: `wbuf_seq`

## Requirements
- R1: After reset, busy, abortFlag and arrWrEn are all low.
- R2: A load sequence starts only when the write following an unlockPulse carries data 0x0025. Its address picks the sector, which is address bits [ADDR_W-1:SECTOR_LSB]. Any other first write after unlockPulse returns the block to idle with no effect, and a 0x0025 write without a preceding unlockPulse is ignored.
- R3: The write after the load command carries the word count minus one and must be in the selected sector. A value above BUF_WORDS-1 (15 by default), or a sector mismatch, aborts. The value BUF_WORDS-1 is accepted.
- R4: The first data write fixes the page, which is address bits [ADDR_W-1:4] by default, and must lie in the selected sector. Any later data write whose page differs aborts.
- R5: Data writes may target page locations in any order. Each write counts as one of the expected words, and a repeated location keeps the data of its latest write.
- R6: After count+1 data writes, the next write must carry data 0x0029 at an address in the selected sector to start the commit. Any other data, or another sector, aborts without any array write.
- R7: Busy rises in the cycle after the confirm and stays high for BUF_WORDS+HOLD_CYCLES cycles. During its first BUF_WORDS cycles, index i is visited in ascending order. Each loaded index writes {page,i} with data arrRdData AND the buffered word, and unloaded indices are not written.
- R8: Writes and unlock pulses that arrive while busy is high have no effect.
- R9: abortFlag stays high until an unlockPulse is followed by a write of data 0x00F0. A 0x00F0 write without that pulse, or any other data after the pulse, leaves it set. Busy and abortFlag are never high together.
- R10: Once busy falls, the block is idle and accepts a new load sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| unlockPulse | input | 1 | One-cycle indication that the unlock write pair has been seen |
| wrEn | input | 1 | Command-bus write strobe |
| wrAddr | input | ADDR_W | Command-bus write address |
| wrData | input | DATA_W | Command-bus write data |
| busy | output | 1 | Commit and settling interval in progress |
| abortFlag | output | 1 | Sticky sequence-error indication |
| arrWrEn | output | 1 | Array write strobe |
| arrAddr | output | ADDR_W | Array address for the read and write of the current index |
| arrWrData | output | DATA_W | Old array word ANDed with the buffered word |
| arrRdData | input | DATA_W | Combinational array read data at arrAddr |

## Verification
The hardest situation to reach is a load where the word count, page ownership and overwrite rules all act in the same run. That means a full 16-word load in descending order, and a load where one location is written twice, so the rewrite uses up one of the counted words. The stimulus builds these runs directly. It then lays a second load over an already programmed word so the AND shows up. It also sends a complete would-abort sequence while busy is high, to show the block ignored it. A behavioural model predicts busy, abort and every array write on each clock and also tracks the expected array contents.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  localparam logic [7:0] CMD_LOAD    = 8'h25;
  localparam logic [7:0] CMD_CONFIRM = 8'h29;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARMED,
    ST_COUNT,
    ST_LOAD,
    ST_CONFIRM,
    ST_COMMIT,
    ST_HOLD,
    ST_ABORT,
    ST_ABORT_ARM
  } seqState_t;

  typedef struct packed {
    logic latchSector;
    logic latchPage;
    logic storeWord;
    logic clearBuf;
    logic commitEn;
  } strobe_t;

endpackage

// File: rtl/wbuf_data.sv
module wbuf_data
  import wbuf_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int BUF_WORDS  = 16,
  parameter int SECTOR_LSB = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [$clog2(BUF_WORDS)-1:0]  commitIdx,
  input  logic [DATA_W-1:0]             arrRdData,
  output logic                          sectorHit,
  output logic                          pageHit,
  output logic                          countTooBig,
  output logic                          arrWrEn,
  output logic [ADDR_W-1:0]             arrAddr,
  output logic [DATA_W-1:0]             arrWrData
);

  localparam int IDX_W  = $clog2(BUF_WORDS);
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam int SECT_W = ADDR_W - SECTOR_LSB;
  localparam logic [DATA_W-1:0] MAX_COUNT = DATA_W'(BUF_WORDS - 1);

  logic [SECT_W-1:0]  sectorQ;
  logic [PAGE_W-1:0]  pageQ;
  logic [IDX_W-1:0]   wrIdx;
  logic [DATA_W-1:0]  entryData [BUF_WORDS];
  logic [BUF_WORDS-1:0] validVec;

  assign wrIdx = wrAddr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectorQ <= '0;
      pageQ   <= '0;
    end else begin
      if (stb.latchSector) sectorQ <= wrAddr[ADDR_W-1:SECTOR_LSB];
      if (stb.latchPage)   pageQ   <= wrAddr[ADDR_W-1:IDX_W];
    end
  end

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_entry
    logic [DATA_W-1:0] dataQ;
    logic              validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ  <= '0;
        validQ <= 1'b0;
      end else if (stb.clearBuf) begin
        validQ <= 1'b0;
      end else if (stb.storeWord && (wrIdx == IDX_W'(g))) begin
        dataQ  <= wrData;
        validQ <= 1'b1;
      end
    end
    assign entryData[g] = dataQ;
    assign validVec[g]  = validQ;
  end

  assign sectorHit   = (wrAddr[ADDR_W-1:SECTOR_LSB] == sectorQ);
  assign pageHit     = (wrAddr[ADDR_W-1:IDX_W] == pageQ);
  assign countTooBig = (wrData > MAX_COUNT);

  assign arrAddr   = {pageQ, commitIdx};
  assign arrWrEn   = stb.commitEn & validVec[commitIdx];
  assign arrWrData = arrRdData & entryData[commitIdx];

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BUF_WORDS   = 16,
  parameter int HOLD_CYCLES = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          unlockPulse,
  input  logic                          wrEn,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          sectorHit,
  input  logic                          pageHit,
  input  logic                          countTooBig,
  output strobe_t                       stb,
  output logic [$clog2(BUF_WORDS)-1:0]  commitIdx,
  output logic                          busy,
  output logic                          abortFlag
);

  localparam int IDX_W  = $clog2(BUF_WORDS);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [DATA_W-1:0] LOAD_CODE    = DATA_W'(CMD_LOAD);
  localparam logic [DATA_W-1:0] CONFIRM_CODE = DATA_W'(CMD_CONFIRM);
  localparam logic [DATA_W-1:0] RESET_CODE   = DATA_W'(CMD_RESET);
  localparam logic [IDX_W-1:0]  LAST_IDX     = IDX_W'(BUF_WORDS - 1);
  localparam logic [HOLD_W-1:0] LAST_HOLD    = HOLD_W'(HOLD_CYCLES - 1);

  seqState_t        stateQ, stateD;
  logic [IDX_W-1:0] targetQ, targetD;
  logic [IDX_W-1:0] pairsQ, pairsD;
  logic [IDX_W-1:0] idxQ, idxD;
  logic [HOLD_W-1:0] holdQ, holdD;
  logic             pairOk;
  logic             firstPair;

  assign firstPair = (pairsQ == '0);
  assign pairOk    = firstPair ? sectorHit : pageHit;

  always_comb begin
    stateD  = stateQ;
    targetD = targetQ;
    pairsD  = pairsQ;
    idxD    = idxQ;
    holdD   = holdQ;
    stb     = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (unlockPulse) stateD = ST_ARMED;
      end
      ST_ARMED: begin
        if (wrEn) begin
          if (wrData == LOAD_CODE) begin
            stb.latchSector = 1'b1;
            stb.clearBuf    = 1'b1;
            stateD          = ST_COUNT;
          end else begin
            stateD = ST_IDLE;
          end
        end
      end
      ST_COUNT: begin
        if (wrEn) begin
          if (!sectorHit || countTooBig) begin
            stateD = ST_ABORT;
          end else begin
            targetD = wrData[IDX_W-1:0];
            pairsD  = '0;
            stateD  = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        if (wrEn) begin
          if (!pairOk) begin
            stateD = ST_ABORT;
          end else begin
            stb.storeWord = 1'b1;
            stb.latchPage = firstPair;
            if (pairsQ == targetQ) stateD = ST_CONFIRM;
            else pairsD = pairsQ + 1'b1;
          end
        end
      end
      ST_CONFIRM: begin
        if (wrEn) begin
          if ((wrData == CONFIRM_CODE) && sectorHit) begin
            idxD   = '0;
            stateD = ST_COMMIT;
          end else begin
            stateD = ST_ABORT;
          end
        end
      end
      ST_COMMIT: begin
        stb.commitEn = 1'b1;
        if (idxQ == LAST_IDX) begin
          holdD  = '0;
          stateD = ST_HOLD;
        end else begin
          idxD = idxQ + 1'b1;
        end
      end
      ST_HOLD: begin
        if (holdQ == LAST_HOLD) stateD = ST_IDLE;
        else holdD = holdQ + 1'b1;
      end
      ST_ABORT: begin
        if (unlockPulse) stateD = ST_ABORT_ARM;
      end
      ST_ABORT_ARM: begin
        if (wrEn) stateD = (wrData == RESET_CODE) ? ST_IDLE : ST_ABORT;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      targetQ <= '0;
      pairsQ  <= '0;
      idxQ    <= '0;
      holdQ   <= '0;
    end else begin
      stateQ  <= stateD;
      targetQ <= targetD;
      pairsQ  <= pairsD;
      idxQ    <= idxD;
      holdQ   <= holdD;
    end
  end

  assign commitIdx = idxQ;
  assign busy      = (stateQ == ST_COMMIT) || (stateQ == ST_HOLD);
  assign abortFlag = (stateQ == ST_ABORT) || (stateQ == ST_ABORT_ARM);

endmodule

// File: rtl/wbuf_seq.sv
module wbuf_seq
  import wbuf_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int BUF_WORDS   = 16,
  parameter int SECTOR_LSB  = 8,
  parameter int HOLD_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              unlockPulse,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              abortFlag,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrWrData,
  input  logic [DATA_W-1:0] arrRdData
);

  localparam int IDX_W = $clog2(BUF_WORDS);

  strobe_t          stb;
  logic [IDX_W-1:0] commitIdx;
  logic             sectorHit;
  logic             pageHit;
  logic             countTooBig;

  wbuf_ctrl #(
    .DATA_W      (DATA_W),
    .BUF_WORDS   (BUF_WORDS),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .unlockPulse (unlockPulse),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .sectorHit   (sectorHit),
    .pageHit     (pageHit),
    .countTooBig (countTooBig),
    .stb         (stb),
    .commitIdx   (commitIdx),
    .busy        (busy),
    .abortFlag   (abortFlag)
  );

  wbuf_data #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BUF_WORDS  (BUF_WORDS),
    .SECTOR_LSB (SECTOR_LSB)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .commitIdx   (commitIdx),
    .arrRdData   (arrRdData),
    .sectorHit   (sectorHit),
    .pageHit     (pageHit),
    .countTooBig (countTooBig),
    .arrWrEn     (arrWrEn),
    .arrAddr     (arrAddr),
    .arrWrData   (arrWrData)
  );

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              busy,
  input logic              abortFlag,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrAddr
);

  localparam logic [DATA_W-1:0] CONFIRM_CODE = DATA_W'(wbuf_pkg::CMD_CONFIRM);
  localparam logic [DATA_W-1:0] RESET_CODE   = DATA_W'(wbuf_pkg::CMD_RESET);

  // R7: array writes happen only inside the busy window
  p_write_in_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);

  // R7: consecutive array writes of one commit walk upward
  p_ascending_r7: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && $past(arrWrEn)) |-> (arrAddr > $past(arrAddr)));

  // R6: busy only rises after an accepted confirm write
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(wrEn) && ($past(wrData) == CONFIRM_CODE)));

  // R9: busy and abort are exclusive
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && abortFlag));

  // R9: abort cannot drop without a write
  p_abort_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (abortFlag && !wrEn) |=> abortFlag);

  // R9: abort clears only through the reset command
  p_abort_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(abortFlag) |-> ($past(wrEn) && ($past(wrData) == RESET_CODE)));

endmodule

bind wbuf_seq wbuf_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .busy      (busy),
  .abortFlag (abortFlag),
  .arrWrEn   (arrWrEn),
  .arrAddr   (arrAddr)
);

// File: tb/wbuf_seq_test.sv
`timescale 1ns/1ps
module wbuf_seq_test;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int BUFW   = 16;
  localparam int HOLD   = 6;
  localparam int BUSYLEN = BUFW + HOLD;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              unlockPulse = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              busy, abortFlag, arrWrEn;
  logic [ADDR_W-1:0] arrAddr;
  logic [DATA_W-1:0] arrWrData, arrRdData;

  logic [DATA_W-1:0] mem    [4096];
  logic [DATA_W-1:0] expMem [4096];

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  always #2.5 clk = ~clk;

  wbuf_seq uut (
    .clk(clk), .rstN(rstN), .unlockPulse(unlockPulse), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .abortFlag(abortFlag),
    .arrWrEn(arrWrEn), .arrAddr(arrAddr), .arrWrData(arrWrData),
    .arrRdData(arrRdData)
  );

  assign arrRdData = mem[arrAddr];

  always @(posedge clk) if (arrWrEn) mem[arrAddr] <= arrWrData;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mState = 0;  // 0 idle 1 armed 2 count 3 load 4 confirm 5 busy 6 abort 7 abort-armed
  int mSector, mPage, mTarget, mPairs, mCnt;
  logic [DATA_W-1:0] mBuf [BUFW];
  bit mValid [BUFW];

  always @(posedge clk) begin
    if (!rstN) mState = 0;
    else begin
      case (mState)
        0: if (unlockPulse) mState = 1;
        1: if (wrEn) begin
             if (wrData == 16'h0025) begin
               mSector = int'(wrAddr >> 8);
               foreach (mValid[k]) mValid[k] = 1'b0;
               mState = 2;
             end else mState = 0;
           end
        2: if (wrEn) begin
             if (int'(wrAddr >> 8) != mSector || wrData > 16'd15) mState = 6;
             else begin mTarget = int'(wrData); mPairs = 0; mState = 3; end
           end
        3: if (wrEn) begin
             bit ok;
             ok = (mPairs == 0) ? (int'(wrAddr >> 8) == mSector) : (int'(wrAddr >> 4) == mPage);
             if (!ok) mState = 6;
             else begin
               if (mPairs == 0) mPage = int'(wrAddr >> 4);
               mBuf[wrAddr[3:0]] = wrData;
               mValid[wrAddr[3:0]] = 1'b1;
               if (mPairs == mTarget) mState = 4; else mPairs++;
             end
           end
        4: if (wrEn) begin
             if (wrData == 16'h0029 && int'(wrAddr >> 8) == mSector) begin
               mState = 5; mCnt = 0;
               for (int k = 0; k < BUFW; k++)
                 if (mValid[k]) expMem[mPage*16+k] = expMem[mPage*16+k] & mBuf[k];
             end else mState = 6;
           end
        5: if (mCnt == BUSYLEN-1) mState = 0; else mCnt++;
        6: if (unlockPulse) mState = 7;
        7: if (wrEn) mState = (wrData == 16'h00F0) ? 0 : 6;
        default: mState = 0;
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (running && rstN) begin
      bit expWr;
      expWr = (mState == 5) && (mCnt < BUFW) && mValid[mCnt];
      check("R7 busy per cycle", 32'(busy), 32'(mState == 5));
      check("R9 abort per cycle", 32'(abortFlag), 32'(mState == 6 || mState == 7));
      check("R7 write strobe per cycle", 32'(arrWrEn), 32'(expWr));
      if (expWr) begin
        check("R7 write address", 32'(arrAddr), 32'(mPage*16 + mCnt));
        check("R7 write data AND", 32'(arrWrData), 32'(mem[mPage*16+mCnt] & mBuf[mCnt]));
      end
    end
  end

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doUnlock();
    @(negedge clk);
    unlockPulse = 1'b1;
    @(negedge clk);
    unlockPulse = 1'b0;
  endtask

  task automatic abortReset();
    doUnlock();
    doWrite(12'h000, 16'h00F0);
  endtask

  task automatic waitIdle();
    repeat (BUSYLEN + 3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin mem[i] = 16'hFFFF; expMem[i] = 16'hFFFF; end
    repeat (3) @(negedge clk);
    check("R1 busy after reset", 32'(busy), 0);
    check("R1 abort after reset", 32'(abortFlag), 0);
    check("R1 no array write after reset", 32'(arrWrEn), 0);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);

    // R2: load command without unlock is ignored, then count write must not abort
    doWrite(12'h300, 16'h0025);
    doWrite(12'h300, 16'h0040);
    check("R2 load without unlock ignored", 32'(abortFlag), 0);
    // R2: unlock then other data returns to idle
    doUnlock();
    doWrite(12'h300, 16'h0090);
    doWrite(12'h300, 16'h0040);
    check("R2 non-load after unlock ignored", 32'(abortFlag), 0);

    // R5: out-of-order load with one rewritten location
    doUnlock();
    doWrite(12'h300, 16'h0025);
    doWrite(12'h3A0, 16'h0005);
    doWrite(12'h315, 16'h5555);
    doWrite(12'h312, 16'h1111);
    doWrite(12'h319, 16'h9999);
    doWrite(12'h310, 16'h0F00);
    doWrite(12'h312, 16'hA5C3);
    doWrite(12'h31F, 16'hFEED);
    doWrite(12'h3F0, 16'h0029);
    check("R7 busy after confirm", 32'(busy), 1);
    // R8: would-abort sequence during busy
    doUnlock();
    doWrite(12'h300, 16'h0025);
    doWrite(12'h300, 16'h0040);
    waitIdle();
    check("R8 writes during busy ignored", 32'(abortFlag), 0);
    check("R10 idle after busy", 32'(busy), 0);
    check("R5 rewrite keeps latest data", 32'(mem[12'h312]), 32'h0000A5C3);
    check("R7 unloaded location untouched", 32'(mem[12'h313]), 32'h0000FFFF);

    // R7: AND into already programmed word, count 0
    doUnlock();
    doWrite(12'h301, 16'h0025);
    doWrite(12'h302, 16'h0000);
    doWrite(12'h312, 16'h0F0F);
    doWrite(12'h3FF, 16'h0029);
    waitIdle();
    check("R7 AND with old contents", 32'(mem[12'h312]), 32'h00000503);

    // R3: count too large aborts; R9 reset rules
    doUnlock();
    doWrite(12'h400, 16'h0025);
    doWrite(12'h400, 16'h0010);
    check("R3 count above max aborts", 32'(abortFlag), 1);
    doWrite(12'h400, 16'h00F0);
    check("R9 reset without unlock kept abort", 32'(abortFlag), 1);
    doUnlock();
    doWrite(12'h400, 16'h0055);
    check("R9 wrong data after unlock kept abort", 32'(abortFlag), 1);
    abortReset();
    check("R9 unlock plus reset clears abort", 32'(abortFlag), 0);

    // R3: max count, descending order (R5)
    doUnlock();
    doWrite(12'h500, 16'h0025);
    doWrite(12'h5AA, 16'h000F);
    for (int k = 15; k >= 0; k--) doWrite(12'h520 + 12'(k), 16'h1000 + 16'(k));
    check("R3 max count not aborted", 32'(abortFlag), 0);
    doWrite(12'h5FF, 16'h0029);
    waitIdle();
    check("R3 max count first word", 32'(mem[12'h520]), 32'h00001000);
    check("R3 max count last word", 32'(mem[12'h52F]), 32'h0000100F);

    // R3: count in another sector aborts
    doUnlock();
    doWrite(12'h600, 16'h0025);
    doWrite(12'h700, 16'h0001);
    check("R3 count outside sector aborts", 32'(abortFlag), 1);
    abortReset();

    // R4: first pair outside sector aborts
    doUnlock();
    doWrite(12'h600, 16'h0025);
    doWrite(12'h600, 16'h0001);
    doWrite(12'h710, 16'h1234);
    check("R4 first pair outside sector aborts", 32'(abortFlag), 1);
    abortReset();

    // R4: page change aborts, nothing written
    doUnlock();
    doWrite(12'h300, 16'h0025);
    doWrite(12'h300, 16'h0003);
    doWrite(12'h330, 16'h0000);
    doWrite(12'h345, 16'h0000);
    check("R4 page change aborts", 32'(abortFlag), 1);
    abortReset();
    repeat (4) @(negedge clk);
    check("R4 aborted page not written", 32'(mem[12'h330]), 32'h0000FFFF);

    // R6: wrong confirm data
    doUnlock();
    doWrite(12'h300, 16'h0025);
    doWrite(12'h300, 16'h0000);
    doWrite(12'h340, 16'h0000);
    doWrite(12'h300, 16'h0030);
    check("R6 wrong confirm aborts", 32'(abortFlag), 1);
    abortReset();
    // R6: confirm in other sector
    doUnlock();
    doWrite(12'h300, 16'h0025);
    doWrite(12'h300, 16'h0000);
    doWrite(12'h340, 16'h0000);
    doWrite(12'h800, 16'h0029);
    check("R6 confirm outside sector aborts", 32'(abortFlag), 1);
    check("R6 no busy after bad confirm", 32'(busy), 0);
    abortReset();
    repeat (4) @(negedge clk);
    check("R6 aborted word not written", 32'(mem[12'h340]), 32'h0000FFFF);

    // whole-array comparison with model
    begin
      int bad = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== expMem[i]) bad++;
      check("R7 array contents match model", 32'(bad), 0);
    end

    running = 1'b0;
    finishRun();
  end

endmodule